// File: doc/BRIEF.md
# Nine-Pixel Grouped Median Selector

This block returns the median of a 3x3 neighbourhood of unsigned greyscale pixels. It is the arithmetic core of an impulse (salt-and-pepper) noise cleaner: an upstream window generator presents all nine pixels of one neighbourhood in parallel, and the block replaces the centre pixel with the neighbourhood median.

The block does not run a full nine-element sort. Each image row of the window (three pixels) is ordered into low, middle and high. Three candidates are then formed: the largest of the row lows, the smallest of the row highs, and the middle of the row middles. The middle of those three candidates is the median of all nine pixels. The default build is purely combinational. A parameter adds one output register stage that also carries a valid flag.

Top module: `median9_select`

## Requirements
- R1: The window is packed into one vector; pixel k (k = 0..8, row-major, top-left first) occupies bits [8k+7:8k] and is treated as an unsigned value from 0 to 255.
- R2: For any window, the output equals the fifth smallest of the nine pixels, so at least five pixels are less than or equal to it and at least five are greater than or equal to it.
- R3: Rows are grouped as pixels 0-2, 3-5 and 6-8; the output equals the middle of (largest row minimum, smallest row maximum, middle of the row middles).
- R4: Repeated values need no special handling: windows with ties give the correct median, and a window of nine equal values gives that value.
- R5: Impulse windows are cleaned: all-0 gives 0, all-255 gives 255, and a window holding only 0 and 255 gives whichever value appears five or more times.
- R6: With REGISTER_OUT = 0 the median and med_valid follow the inputs in the same cycle, with med_valid equal to in_valid.
- R7: With REGISTER_OUT = 1 the median of the window present at a rising clock edge appears on the output after that edge, and med_valid equals in_valid from that edge.
- R8: With REGISTER_OUT = 1 a synchronous active-high reset clears med_valid and med_out to 0 at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used only when the output register is enabled |
| rst | input | 1 | Synchronous active-high reset of the output register |
| in_valid | input | 1 | Window qualifier from the upstream stage |
| win_pix | input | 9*PIX_W | Nine packed window pixels, row-major |
| med_out | output | PIX_W | Median of the window |
| med_valid | output | 1 | Qualifier for med_out |

## Verification
The bench targets windows where a grouped reduction is easy to get wrong: ties across rows, all-equal windows, and 0/255 impulse mixtures where the majority flips between four and five occurrences; a wrong candidate rule (for example a minimum of minimums) gives an extreme value rather than the median on such windows. Random windows are compared against a full sort of the nine values, which catches a swapped comparison or a misrouted pixel. In the registered build it checks that data and valid both appear one edge late and that reset clears them, since an off-by-one stage or an uncleared flag would emit a stale pixel as valid.

// File: rtl/median9_pkg.sv
package median9_pkg;
  localparam int WIN_SIDE = 3;
  localparam int WIN_N    = WIN_SIDE * WIN_SIDE;
  localparam int RANK_W   = $clog2(WIN_N + 1);
  localparam int HALF_N   = (WIN_N + 1) / 2;
endpackage

// File: rtl/sort3_unit.sv
module sort3_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] lo,
  output logic [W-1:0] mid,
  output logic [W-1:0] hi
);
  logic [W-1:0] s_lo, s_hi, t;

  always_comb begin
    // first pair ordered
    if (a > b) begin s_lo = b; s_hi = a; end
    else       begin s_lo = a; s_hi = b; end
    // third value against the larger
    if (c > s_hi) begin hi = c;    t = s_hi; end
    else          begin hi = s_hi; t = c;    end
    // remainder against the smaller
    if (t > s_lo) begin lo = s_lo; mid = t;    end
    else          begin lo = t;    mid = s_lo; end
  end

  always_comb begin
    assert_row_order_R3: assert (lo <= mid && mid <= hi);
  end
endmodule

// File: rtl/cand_stage.sv
module cand_stage #(
  parameter int W = 8
) (
  input  logic [W-1:0] lo_set  [3],
  input  logic [W-1:0] mid_set [3],
  input  logic [W-1:0] hi_set  [3],
  output logic [W-1:0] cand_a,
  output logic [W-1:0] cand_b,
  output logic [W-1:0] cand_c
);
  logic [W-1:0] a01, b01, m_lo, m_hi, m_t;

  always_comb begin
    a01    = (lo_set[1] > lo_set[0]) ? lo_set[1] : lo_set[0];
    cand_a = (lo_set[2] > a01) ? lo_set[2] : a01;
    b01    = (hi_set[0] > hi_set[1]) ? hi_set[1] : hi_set[0];
    cand_b = (b01 > hi_set[2]) ? hi_set[2] : b01;
    m_lo   = (mid_set[0] > mid_set[1]) ? mid_set[1] : mid_set[0];
    m_hi   = (mid_set[0] > mid_set[1]) ? mid_set[0] : mid_set[1];
    m_t    = (mid_set[2] > m_hi) ? m_hi : mid_set[2];
    cand_c = (m_t > m_lo) ? m_t : m_lo;
  end

  always_comb begin
    assert_mid_pick_R3: assert (cand_c == mid_set[0] || cand_c == mid_set[1] ||
                                cand_c == mid_set[2]);
    assert_lo_pick_R3: assert (cand_a >= lo_set[0] && cand_a >= lo_set[1] &&
                               cand_a >= lo_set[2]);
  end
endmodule

// File: rtl/median9_select.sv
module median9_select
  import median9_pkg::*;
#(
  parameter int PIX_W        = 8,
  parameter bit REGISTER_OUT = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [WIN_N*PIX_W-1:0] win_pix,
  output logic [PIX_W-1:0]       med_out,
  output logic                   med_valid
);
  logic [PIX_W-1:0] pix     [WIN_N];
  logic [PIX_W-1:0] row_lo  [WIN_SIDE];
  logic [PIX_W-1:0] row_mid [WIN_SIDE];
  logic [PIX_W-1:0] row_hi  [WIN_SIDE];
  logic [PIX_W-1:0] cand_a, cand_b, cand_c;
  logic [PIX_W-1:0] f_lo, f_hi, f_t, med_comb;

  for (genvar k = 0; k < WIN_N; k++) begin : g_unpack
    assign pix[k] = win_pix[k*PIX_W +: PIX_W];
  end

  for (genvar r = 0; r < WIN_SIDE; r++) begin : g_row
    sort3_unit #(.W(PIX_W)) u_row (
      .a  (pix[r*WIN_SIDE]),
      .b  (pix[r*WIN_SIDE+1]),
      .c  (pix[r*WIN_SIDE+2]),
      .lo (row_lo[r]),
      .mid(row_mid[r]),
      .hi (row_hi[r])
    );
  end

  cand_stage #(.W(PIX_W)) u_cand (
    .lo_set (row_lo),
    .mid_set(row_mid),
    .hi_set (row_hi),
    .cand_a (cand_a),
    .cand_b (cand_b),
    .cand_c (cand_c)
  );

  // middle of the three candidates
  always_comb begin
    f_lo     = (cand_a > cand_b) ? cand_b : cand_a;
    f_hi     = (cand_a > cand_b) ? cand_a : cand_b;
    f_t      = (cand_c > f_hi) ? f_hi : cand_c;
    med_comb = (f_t > f_lo) ? f_t : f_lo;
  end

  if (REGISTER_OUT) begin : g_reg
    logic [PIX_W-1:0] med_q;
    logic             val_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        med_q <= '0;
        val_q <= 1'b0;
      end else begin
        med_q <= med_comb;
        val_q <= in_valid;
      end
    end
    assign med_out   = med_q;
    assign med_valid = val_q;

    assert_valid_delay_R7: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> med_valid == $past(in_valid));
    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!med_valid && med_out == '0));
  end else begin : g_comb
    assign med_out   = med_comb;
    assign med_valid = in_valid;
  end

  // rank checker on the combinational median
  logic [RANK_W-1:0] n_le, n_ge;
  logic              all_same;
  always_comb begin
    n_le     = '0;
    n_ge     = '0;
    all_same = 1'b1;
    for (int k = 0; k < WIN_N; k++) begin
      n_le = n_le + RANK_W'(pix[k] <= med_comb);
      n_ge = n_ge + RANK_W'(pix[k] >= med_comb);
      if (pix[k] != pix[0]) all_same = 1'b0;
    end
  end

  assert_rank_R2: assert property (@(posedge clk) disable iff (rst)
    (n_le >= RANK_W'(HALF_N)) && (n_ge >= RANK_W'(HALF_N)));
  assert_uniform_R4: assert property (@(posedge clk) disable iff (rst)
    all_same |-> med_comb == pix[0]);
endmodule

// File: tb/sim_median9_select.sv
module sim_median9_select;
  localparam int W = 8;
  localparam int N = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [N*W-1:0] win = '0;
  logic [W-1:0] c_out, r_out;
  logic c_val, r_val;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  median9_select #(.PIX_W(W), .REGISTER_OUT(1'b0)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .win_pix(win),
    .med_out(c_out), .med_valid(c_val));

  median9_select #(.PIX_W(W), .REGISTER_OUT(1'b1)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .win_pix(win),
    .med_out(r_out), .med_valid(r_val));

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ref_median(logic [N*W-1:0] v);
    int s[N];
    for (int i = 0; i < N; i++) s[i] = int'(v[i*W +: W]);
    for (int i = 1; i < N; i++)
      for (int j = i; j > 0 && s[j-1] > s[j]; j--) begin
        int t = s[j]; s[j] = s[j-1]; s[j-1] = t;
      end
    return s[4];
  endfunction

  function automatic int mid3(int a, int b, int c);
    int mx = (a > b) ? a : b;
    int mn = (a > b) ? b : a;
    return (c > mx) ? mx : ((c < mn) ? mn : c);
  endfunction

  function automatic int grouped(logic [N*W-1:0] v);
    int lo[3]; int md[3]; int hi[3];
    for (int r = 0; r < 3; r++) begin
      int a = int'(v[(3*r)*W +: W]);
      int b = int'(v[(3*r+1)*W +: W]);
      int c = int'(v[(3*r+2)*W +: W]);
      lo[r] = (a < b) ? ((a < c) ? a : c) : ((b < c) ? b : c);
      hi[r] = (a > b) ? ((a > c) ? a : c) : ((b > c) ? b : c);
      md[r] = mid3(a, b, c);
    end
    return mid3((lo[0] > lo[1]) ? ((lo[0] > lo[2]) ? lo[0] : lo[2]) : ((lo[1] > lo[2]) ? lo[1] : lo[2]),
                (hi[0] < hi[1]) ? ((hi[0] < hi[2]) ? hi[0] : hi[2]) : ((hi[1] < hi[2]) ? hi[1] : hi[2]),
                mid3(md[0], md[1], md[2]));
  endfunction

  // drive, check combinational copy, then the registered copy after the edge
  task automatic apply(logic [N*W-1:0] v, logic vld, string tag);
    int exp;
    @(negedge clk);
    win = v;
    in_valid = vld;
    exp = ref_median(v);
    #1;
    check({tag, " comb R6"}, int'(c_out), exp);
    check("R6 valid passthrough", int'(c_val), int'(vld));
    @(posedge clk);
    #1;
    check({tag, " reg R7"}, int'(r_out), exp);
    check("R7 valid delay", int'(r_val), int'(vld));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R8 reset valid", int'(r_val), 0);
    check("R8 reset data", int'(r_out), 0);
    in_valid = 1'b1;
    win = {9{8'd77}};
    @(negedge clk);
    check("R8 held in reset", int'(r_val), 0);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R8 released valid", int'(r_val), 1);
    check("R8 released data", int'(r_out), 77);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R8 mid-run reset valid", int'(r_val), 0);
    check("R8 mid-run reset data", int'(r_out), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_positions();
    // single large value moved through each slot: median stays 10
    for (int k = 0; k < N; k++) begin
      logic [N*W-1:0] v = {9{8'd10}};
      v[k*W +: W] = 8'd200;
      apply(v, 1'b1, "R1 slot");
    end
    // ascending by position, low half at high indices
    apply({8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8, 8'd9}, 1'b1, "R1 order");
    apply({8'd255, 8'd0, 8'd128, 8'd127, 8'd129, 8'd1, 8'd254, 8'd64, 8'd192}, 1'b1, "R1 spread");
  endtask

  task automatic t_random();
    for (int n = 0; n < 300; n++) begin
      logic [N*W-1:0] v;
      for (int k = 0; k < N; k++) v[k*W +: W] = W'($urandom);
      check("R3 grouped rule", grouped(v), ref_median(v));
      apply(v, n[0], "R2 random");
    end
    // rows already sorted across groups: candidates disagree strongly
    apply({8'd90, 8'd80, 8'd70, 8'd60, 8'd50, 8'd40, 8'd30, 8'd20, 8'd10}, 1'b1, "R3 split rows");
    apply({8'd9, 8'd200, 8'd5, 8'd201, 8'd3, 8'd202, 8'd7, 8'd100, 8'd8}, 1'b1, "R3 mixed rows");
  endtask

  task automatic t_ties();
    apply({9{8'd42}}, 1'b1, "R4 uniform");
    apply({8'd5, 8'd5, 8'd5, 8'd5, 8'd9, 8'd9, 8'd9, 8'd9, 8'd9}, 1'b1, "R4 two levels");
    apply({8'd7, 8'd3, 8'd7, 8'd3, 8'd7, 8'd3, 8'd7, 8'd3, 8'd5}, 1'b1, "R4 alternating");
    for (int n = 0; n < 60; n++) begin
      logic [N*W-1:0] v;
      for (int k = 0; k < N; k++) v[k*W +: W] = W'($urandom_range(3) * 20);
      apply(v, 1'b1, "R4 few levels");
    end
  endtask

  task automatic t_impulse();
    apply({9{8'd0}}, 1'b1, "R5 all zero");
    apply({9{8'd255}}, 1'b1, "R5 all full");
    // exactly four 255s: median 0; exactly five: median 255
    apply({8'd0, 8'd255, 8'd0, 8'd255, 8'd0, 8'd255, 8'd0, 8'd255, 8'd0}, 1'b1, "R5 four salt");
    apply({8'd255, 8'd0, 8'd255, 8'd0, 8'd255, 8'd0, 8'd255, 8'd0, 8'd255}, 1'b1, "R5 five salt");
    for (int n = 0; n < 80; n++) begin
      logic [N*W-1:0] v;
      for (int k = 0; k < N; k++) begin
        int sel = $urandom_range(3);
        v[k*W +: W] = (sel == 0) ? 8'd0 : (sel == 1) ? 8'd255 : W'($urandom_range(254, 1));
      end
      apply(v, 1'b1, "R5 noisy");
    end
  endtask

  task automatic finish_up();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_positions();
    t_random();
    t_ties();
    t_impulse();
    finish_up();
  end

  initial begin
    #(20 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_up();
  end
endmodule